// File: doc/BRIEF.md
# Multi-Channel Output Compare Unit

The unit watches the visible value of a shared free-running timer and raises a flag when the timer reaches a value that software chose. It has five channels. Each channel holds a 16-bit compare value, which is written one byte at a time, high byte and low byte. Each channel also has an enable bit. When the timer value equals a channel's compare value and that channel is enabled, the channel's flag is set. Software clears flags by writing ones to them. All flags that are enabled together drive one interrupt request.

The timer is not part of this unit. The timer provides `count_i`, which is its value after prescaling. It also pulses `count_upd_i` in the cycle in which `count_i` takes a new value. A match is counted only in that cycle, so a value that is held over many prescaled cycles sets a flag at most once.

The address map has 12 byte locations:
- Addresses 0 to 9 hold the compare registers. Channel k uses address 2(k-1) for its high byte and 2(k-1)+1 for its low byte.
- Address 10 is the enable register.
- Address 11 is the flag register.
- All other addresses read as zero.

Reads are combinational.

Top module: `ocu_top`

## Requirements
- R1: After reset, every compare byte, the enable register and the flag register read 0, and `irq_o` is low.
- R2: A write to address 2(k-1) loads bits 15:8 of channel k's compare value, and a write to address 2(k-1)+1 loads bits 7:0. Both bytes read back at the same addresses.
- R3: Channel k maps to bit 8-k of both the enable register (address 10) and the flag register (address 11): channel 1 is bit 7 and channel 5 is bit 3. Bits 2:0 of both registers read 0, and writes to those bits are ignored.
- R4: When `count_upd_i` is high, `count_i` equals channel k's compare value and channel k is enabled, flag k is set at the next clock edge.
- R5: A disabled channel never sets its flag, even when the counter matches its compare value.
- R6: A match is counted only in a cycle where `count_upd_i` is high. Holding `count_i` at the compare value while `count_upd_i` is low sets no flag.
- R7: Writing the flag register clears each flag whose written bit is 1. Flags whose written bit is 0 keep their value.
- R8: If a match sets a flag in the same cycle as a write that clears that flag, the flag ends up set.
- R9: `irq_o` is high exactly when some channel has both its flag and its enable bit set. Clearing an enable bit drops that channel's contribution to `irq_o` but leaves its flag in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | 16 | Timer value after prescaling |
| count_upd_i | input | 1 | High in the cycle in which `count_i` takes a new value |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Combined compare interrupt request |

## Verification
The bench goes after five corner cases:
- **Bit order.** It matches every channel on its own and looks at which flag bit rises. A design with the bit order reversed would flag bit 3 when channel 1 matches.
- **Held counter value.** It holds the counter at a compare value with no update pulse, after a flag has been cleared. A design that compared on every cycle would set the flag again.
- **Set and clear in the same cycle.** It lands a match in the same cycle as a write that clears the same flag. A design that gave the clear priority would lose the event.
- **Enable and interrupt.** It drops an enable bit while that channel's flag is pending. A design that gated the flag instead of the interrupt would lose the flag, and one that did not gate at all would keep `irq_o` high.
- **Unused low bits.** It writes the low bits of the enable and flag registers to confirm that they stay at zero.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  localparam int unsigned OCU_DATA_W = 8;

  // register bit position of channel index i (channel i+1), MSB first
  function automatic int unsigned ch_bit(int unsigned data_w, int unsigned i);
    return data_w - 1 - i;
  endfunction
endpackage

// File: rtl/ocu_chan.sv
module ocu_chan #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned HI_ADDR = 0,
  parameter int unsigned LO_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              count_upd_i,
  input  logic              en_i,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              hit_o
);
  logic [CNT_W-1:0] cmp_q;
  logic             wr_hi, wr_lo;

  assign wr_hi = wr_en_i && (addr_i == ADDR_W'(HI_ADDR));
  assign wr_lo = wr_en_i && (addr_i == ADDR_W'(LO_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
    end else begin
      if (wr_hi) cmp_q[CNT_W-1:DATA_W] <= wdata_i;
      if (wr_lo) cmp_q[DATA_W-1:0]     <= wdata_i;
    end
  end

  // comparator idle unless channel enabled and counter just advanced
  assign hit_o = count_upd_i && en_i && (count_i == cmp_q);
  assign cmp_o = cmp_q;

  // R2
  cmp_hi_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi |=> cmp_o[CNT_W-1:DATA_W] == $past(wdata_i));
  // R2
  cmp_lo_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |=> cmp_o[DATA_W-1:0] == $past(wdata_i));
endmodule

// File: rtl/ocu_ctrl.sv
module ocu_ctrl #(
  parameter int unsigned N_CH = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_wr_i,
  input  logic            flg_wr_i,
  input  logic [N_CH-1:0] wbits_i,
  input  logic [N_CH-1:0] hit_i,
  output logic [N_CH-1:0] en_o,
  output logic [N_CH-1:0] flag_o,
  output logic            irq_o
);
  logic [N_CH-1:0] en_q, flag_q, clr;

  assign clr = flg_wr_i ? wbits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (en_wr_i) en_q <= wbits_i;
      // set has priority over write-one-clear
      flag_q <= (flag_q & ~clr) | hit_i;
    end
  end

  assign en_o   = en_q;
  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & en_q);

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    // R4 R8
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i[i] |=> flag_o[i]);
    // R7
    flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr[i] && !hit_i[i]) |=> !flag_o[i]);
  end

  // R9
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o == '0) |-> !irq_o);
endmodule

// File: rtl/ocu_top.sv
module ocu_top #(
  parameter int unsigned N_CH   = 5,
  parameter int unsigned DATA_W = ocu_pkg::OCU_DATA_W,
  parameter int unsigned CNT_W  = 2 * DATA_W,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              count_upd_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  import ocu_pkg::*;

  localparam int unsigned EN_ADDR  = 2 * N_CH;
  localparam int unsigned FLG_ADDR = 2 * N_CH + 1;

  logic [N_CH-1:0]  en, flag, hit, wbits;
  logic [CNT_W-1:0] cmp [N_CH];
  logic             en_wr, flg_wr;
  logic [DATA_W-1:0] en_byte, flg_byte;

  assign en_wr  = wr_en_i && (addr_i == ADDR_W'(EN_ADDR));
  assign flg_wr = wr_en_i && (addr_i == ADDR_W'(FLG_ADDR));

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign wbits[i] = wdata_i[ch_bit(DATA_W, i)];

    ocu_chan #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W),
      .HI_ADDR(2 * i),
      .LO_ADDR(2 * i + 1)
    ) chan_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i),
      .count_i    (count_i),
      .count_upd_i(count_upd_i),
      .en_i       (en[i]),
      .cmp_o      (cmp[i]),
      .hit_o      (hit[i])
    );

    // R5
    flag_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag[i]) |-> $past(en[i]));
    // R6
    flag_needs_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag[i]) |-> $past(count_upd_i));
  end

  ocu_ctrl #(.N_CH(N_CH)) ctrl_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_wr_i (en_wr),
    .flg_wr_i(flg_wr),
    .wbits_i (wbits),
    .hit_i   (hit),
    .en_o    (en),
    .flag_o  (flag),
    .irq_o   (irq_o)
  );

  always_comb begin
    en_byte  = '0;
    flg_byte = '0;
    for (int i = 0; i < N_CH; i++) begin
      en_byte[ch_bit(DATA_W, i)]  = en[i];
      flg_byte[ch_bit(DATA_W, i)] = flag[i];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (addr_i == ADDR_W'(2 * i))     rdata_o = cmp[i][CNT_W-1:DATA_W];
      if (addr_i == ADDR_W'(2 * i + 1)) rdata_o = cmp[i][DATA_W-1:0];
    end
    if (addr_i == ADDR_W'(EN_ADDR))  rdata_o = en_byte;
    if (addr_i == ADDR_W'(FLG_ADDR)) rdata_o = flg_byte;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !irq_o);
endmodule

// File: tb/ocu_top_tb_top.sv
module ocu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] count = '0;
  logic        upd = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [3:0] EN_A = 4'd10;
  localparam logic [3:0] FL_A = 4'd11;

  always #10 clk = ~clk;

  ocu_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .count_i(count), .count_upd_i(upd),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic tick(logic [15:0] v);
    @(negedge clk);
    count = v; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic set_cmp(int k, logic [15:0] v);
    wr(4'(2 * (k - 1)), v[15:8]);
    wr(4'(2 * (k - 1) + 1), v[7:0]);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), d);
      check("R1 reset read", {8'h0, d}, 16'h0);
    end
    check("R1 reset irq", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_cmp_rw();
    logic [7:0] d;
    for (int k = 1; k <= 5; k++) set_cmp(k, 16'(16'hA150 + k * 16'h0F03));
    for (int k = 1; k <= 5; k++) begin
      logic [15:0] e;
      e = 16'(16'hA150 + k * 16'h0F03);
      rd(4'(2 * (k - 1)), d);
      check("R2 cmp hi", {8'h0, d}, {8'h0, e[15:8]});
      rd(4'(2 * (k - 1) + 1), d);
      check("R2 cmp lo", {8'h0, d}, {8'h0, e[7:0]});
    end
    rd(4'd13, d);
    check("R2 unmapped read", {8'h0, d}, 16'h0);
  endtask

  task automatic t_mapping();
    logic [7:0] d;
    wr(EN_A, 8'h40);
    rd(EN_A, d);
    check("R3 enable ch2 bit", {8'h0, d}, 16'h0040);
    wr(EN_A, 8'hFF);
    rd(EN_A, d);
    check("R3 enable low bits", {8'h0, d}, 16'h00F8);
    for (int k = 1; k <= 5; k++) begin
      set_cmp(k, 16'(16'h0300 + k));
      tick(16'(16'h0300 + k));
      rd(FL_A, d);
      check("R3 R4 flag bit of channel", {8'h0, d}, {8'h0, 8'(8'h80 >> (k - 1))});
      wr(FL_A, 8'hFF);
      rd(FL_A, d);
      check("R7 clear all", {8'h0, d}, 16'h0);
    end
  endtask

  task automatic t_match();
    logic [7:0] d;
    wr(EN_A, 8'h80);
    set_cmp(1, 16'h1234);
    tick(16'h1233);
    rd(FL_A, d);
    check("R4 no flag off by one", {8'h0, d}, 16'h0);
    check("R9 irq low", {15'h0, irq}, 16'h0);
    tick(16'h1234);
    rd(FL_A, d);
    check("R4 flag on match", {8'h0, d}, 16'h0080);
    check("R9 irq high", {15'h0, irq}, 16'h1);
    wr(FL_A, 8'h80);
  endtask

  task automatic t_disabled_hold();
    logic [7:0] d;
    wr(EN_A, 8'h80);
    set_cmp(3, 16'h5555);
    tick(16'h5555);
    rd(FL_A, d);
    check("R5 disabled channel", {8'h0, d}, 16'h0);
    check("R5 irq", {15'h0, irq}, 16'h0);
    set_cmp(1, 16'h7777);
    @(negedge clk);
    count = 16'h7777;
    repeat (4) @(negedge clk);
    rd(FL_A, d);
    check("R6 no update no flag", {8'h0, d}, 16'h0);
    tick(16'h7777);
    wr(FL_A, 8'h80);
    repeat (4) @(negedge clk);
    rd(FL_A, d);
    check("R6 held value no reflag", {8'h0, d}, 16'h0);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    wr(EN_A, 8'hC0);
    set_cmp(1, 16'h0100);
    set_cmp(2, 16'h0100);
    tick(16'h0100);
    rd(FL_A, d);
    check("R4 two flags", {8'h0, d}, 16'h00C0);
    wr(FL_A, 8'h00);
    rd(FL_A, d);
    check("R7 zero write keeps", {8'h0, d}, 16'h00C0);
    wr(FL_A, 8'h40);
    rd(FL_A, d);
    check("R7 partial clear", {8'h0, d}, 16'h0080);
    wr(FL_A, 8'h80);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    wr(EN_A, 8'h80);
    set_cmp(1, 16'h0200);
    @(negedge clk);
    wr_en = 1'b1; addr = FL_A; wdata = 8'h80;
    count = 16'h0200; upd = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; upd = 1'b0;
    rd(FL_A, d);
    check("R8 set wins over clear", {8'h0, d}, 16'h0080);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    check("R9 irq with pending flag", {15'h0, irq}, 16'h1);
    wr(EN_A, 8'h00);
    check("R9 irq off when disabled", {15'h0, irq}, 16'h0);
    rd(FL_A, d);
    check("R9 flag kept", {8'h0, d}, 16'h0080);
    wr(EN_A, 8'h80);
    check("R9 irq back", {15'h0, irq}, 16'h1);
    wr(FL_A, 8'h80);
    check("R9 irq after clear", {15'h0, irq}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_cmp_rw();
    t_mapping();
    t_match();
    t_disabled_hold();
    t_clear();
    t_set_wins();
    t_irq();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule